// File: doc/BRIEF.md
# CAN Bus-Integration Mode Controller

This block governs the passage of a CAN controller between its configuration state and normal bus operation. Software raises a request input to hold the controller in configuration; while it is held, the transmit pin is forced recessive and an acknowledge output reports that the controller is off the bus. When software drops the request, the controller does not join the bus at once. It waits until it has seen a long enough stretch of idle bus, so that it cannot start transmitting in the middle of a frame sent by another node.

The received level is sampled only on a one-cycle bit strobe supplied by an external bit-timing unit. A counter tracks how many consecutive samples have read recessive. Any dominant sample sends the counter back to zero. When the run reaches the configured length, the block raises a synchronized flag and drops the acknowledge output on the same edge. An undriven bus reads recessive, so a quiet bus is enough to complete the run. A receive line that is stuck dominant keeps the controller in configuration indefinitely. A loopback input routes the block's own transmit level into the receive path, so the controller can synchronize and run without any external bus.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, initAck is 1, syncOk is 0 and txPin is 1 (recessive). On both pins, logic 1 means recessive and logic 0 means dominant.
- R2: While initAck is 1, txPin is 1, whatever value txBit has.
- R3: While initAck is 0, txPin follows txBit.
- R4: With initReq low and initAck high, 11 consecutive bit ticks that sample a recessive rxBit clear initAck and set syncOk on the clock edge of the 11th tick. After only 10 such ticks, initAck is still 1.
- R5: A dominant sample on a tick during the run resets the count, so 11 more consecutive recessive ticks are needed after it.
- R6: If the receive level stays dominant, initAck stays 1 and syncOk stays 0 however many ticks occur.
- R7: The receive level is sampled only in cycles where bitTick is 1. Dominant levels between ticks do not affect the count, and initAck and syncOk change only on tick edges.
- R8: When initReq is 1 in normal mode, the next tick sets initAck to 1 and clears syncOk.
- R9: While initReq is 1, recessive ticks are not counted, and initAck stays 1.
- R10: With loopEn at 1, rxBit equals txPin and rxPin is ignored, so synchronization completes even when rxPin is held dominant.
- R11: With loopEn at 0, rxBit equals rxPin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bitTick | input | 1 | One-cycle strobe marking each bit sample point |
| initReq | input | 1 | Software request to enter or stay in configuration mode |
| loopEn | input | 1 | Internal loopback from the transmit path to the receive path |
| rxPin | input | 1 | Receive level from the transceiver (1 = recessive) |
| txBit | input | 1 | Transmit level from the protocol engine |
| txPin | output | 1 | Transmit level to the transceiver (1 = recessive) |
| rxBit | output | 1 | Receive level delivered to the protocol engine |
| initAck | output | 1 | High while the controller is in configuration mode |
| syncOk | output | 1 | High once the idle run has completed |

## Verification
Synchronization is tried with a clean run of exactly eleven recessive ticks, checked at the tenth and the eleventh tick, to separate a correct threshold from an off-by-one. A run broken by a single dominant tick shows whether the counter restarts or only pauses. A permanently dominant line and a held request show that nothing counts when it should not. A run with dominant noise placed only between ticks shows that samples are taken on the strobe alone. Loopback with a dominant external line shows whether the receive path really comes from the transmit side.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic {
    MODE_CONFIG = 1'b0,
    MODE_RUN    = 1'b1
  } modeE;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } cntCmdT;
endpackage

// File: rtl/can_mode_dp.sv
module can_mode_dp
  import can_mode_pkg::*;
#(
  parameter int SYNC_BITS = 11,
  localparam int CNT_W = $clog2(SYNC_BITS + 1)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  cntCmdT cmd,
  input  logic   initAck,
  input  logic   loopEn,
  input  logic   rxPin,
  input  logic   txBit,
  output logic   txPin,
  output logic   rxBit,
  output logic   lastBit,
  output logic   syncOk
);
  logic [CNT_W-1:0] runCnt;

  // recessive output while off the bus
  assign txPin = initAck ? 1'b1 : txBit;
  // loopback takes the internal transmit level
  assign rxBit = loopEn ? txPin : rxPin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runCnt <= '0;
    end else if (cmd.cntClr) begin
      runCnt <= '0;
    end else if (cmd.cntInc && (runCnt != CNT_W'(SYNC_BITS))) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  assign lastBit = (runCnt == CNT_W'(SYNC_BITS - 1));
  assign syncOk  = (runCnt == CNT_W'(SYNC_BITS));
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bitTick,
  input  logic   initReq,
  input  logic   rxBit,
  input  logic   lastBit,
  output cntCmdT cmd,
  output logic   initAck
);
  modeE mode, modeNxt;

  always_comb begin
    modeNxt = mode;
    cmd     = '0;
    if (bitTick) begin
      unique case (mode)
        MODE_CONFIG: begin
          if (initReq) begin
            cmd.cntClr = 1'b1;
          end else if (rxBit) begin
            cmd.cntInc = 1'b1;
            if (lastBit) modeNxt = MODE_RUN;
          end else begin
            cmd.cntClr = 1'b1;
          end
        end
        MODE_RUN: begin
          if (initReq) begin
            cmd.cntClr = 1'b1;
            modeNxt    = MODE_CONFIG;
          end
        end
        default: modeNxt = MODE_CONFIG;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= MODE_CONFIG;
    else        mode <= modeNxt;
  end

  assign initAck = (mode == MODE_CONFIG);
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int SYNC_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bitTick,
  input  logic initReq,
  input  logic loopEn,
  input  logic rxPin,
  input  logic txBit,
  output logic txPin,
  output logic rxBit,
  output logic initAck,
  output logic syncOk
);
  cntCmdT cmd;
  logic   lastBit;

  can_mode_fsm fsmI (
    .clk     (clk),
    .rst_n   (rst_n),
    .bitTick (bitTick),
    .initReq (initReq),
    .rxBit   (rxBit),
    .lastBit (lastBit),
    .cmd     (cmd),
    .initAck (initAck)
  );

  can_mode_dp #(.SYNC_BITS(SYNC_BITS)) dpI (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .initAck (initAck),
    .loopEn  (loopEn),
    .rxPin   (rxPin),
    .txBit   (txBit),
    .txPin   (txPin),
    .rxBit   (rxBit),
    .lastBit (lastBit),
    .syncOk  (syncOk)
  );
endmodule

// File: rtl/can_mode_chk.sv
module can_mode_chk (
  input logic clk,
  input logic rst_n,
  input logic bitTick,
  input logic initReq,
  input logic loopEn,
  input logic rxPin,
  input logic txBit,
  input logic txPin,
  input logic rxBit,
  input logic initAck,
  input logic syncOk
);
  // R2
  tx_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    initAck |-> txPin);

  // R4
  ack_sync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    initAck != syncOk);

  // R6
  dominant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (initAck && bitTick && !rxBit) |=> initAck);

  // R7
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bitTick |=> ($stable(initAck) && $stable(syncOk)));

  // R8
  req_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bitTick && initReq) |=> (initAck && !syncOk));

  // R10
  loop_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loopEn |-> (rxBit == txPin));
endmodule

bind can_mode_ctrl can_mode_chk chkI (.*);

// File: tb/can_mode_ctrl_test.sv
module can_mode_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bitTick = 1'b0;
  logic initReq = 1'b1;
  logic loopEn = 1'b0;
  logic rxPin = 1'b1;
  logic txBit = 1'b1;
  logic txPin, rxBit, initAck, syncOk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  ack;
    logic  sync;
    string tag;
  } expT;
  expT sbQ[$];

  // reference state derived from the requirements
  logic mAck = 1'b1;
  int   mRun = 0;

  always #10 clk = ~clk;

  can_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bitTick(bitTick), .initReq(initReq),
    .loopEn(loopEn), .rxPin(rxPin), .txBit(txBit), .txPin(txPin),
    .rxBit(rxBit), .initAck(initAck), .syncOk(syncOk)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item after every tick edge
  always @(posedge clk) begin
    #2;
    if (sbQ.size() > 0) begin
      expT e;
      e = sbQ.pop_front();
      check(initAck, e.ack, {e.tag, " initAck"});
      check(syncOk, e.sync, {e.tag, " syncOk"});
    end
  end

  // driver: one tick, optional dominant noise on rxPin in the gap cycle
  task automatic tick(input logic rx, input logic req, input logic noise, input string tag);
    logic eff;
    @(negedge clk);
    rxPin = rx;
    initReq = req;
    bitTick = 1'b1;
    eff = loopEn ? (mAck ? 1'b1 : txBit) : rx;
    if (req) begin
      mAck = 1'b1;
      mRun = 0;
    end else if (mAck) begin
      if (eff) begin
        mRun++;
        if (mRun == 11) mAck = 1'b0;
      end else begin
        mRun = 0;
      end
    end
    sbQ.push_back('{ack: mAck, sync: !mAck, tag: tag});
    @(negedge clk);
    bitTick = 1'b0;
    if (noise) rxPin = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
  end

  initial begin
    txBit = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(initAck, 1'b1, "R1 initAck");
    check(syncOk, 1'b0, "R1 syncOk");
    check(txPin, 1'b1, "R1/R2 txPin");
    rst_n = 1'b1;
    @(negedge clk);
    check(txPin, 1'b1, "R2 txPin forced recessive");

    // R9 request held with a recessive line
    for (int i = 0; i < 15; i++) tick(1'b1, 1'b1, 1'b0, "R9");

    // R4 clean run of eleven
    for (int i = 0; i < 11; i++) tick(1'b1, 1'b0, 1'b0, "R4");
    @(negedge clk);
    txBit = 1'b0;
    #1 check(txPin, 1'b0, "R3 txPin low");
    txBit = 1'b1;
    #1 check(txPin, 1'b1, "R3 txPin high");
    rxPin = 1'b0;
    #1 check(rxBit, 1'b0, "R11 rxBit low");
    rxPin = 1'b1;
    #1 check(rxBit, 1'b1, "R11 rxBit high");

    // R8 request from normal mode
    tick(1'b1, 1'b1, 1'b0, "R8");

    // R5 broken run
    for (int i = 0; i < 6; i++) tick(1'b1, 1'b0, 1'b0, "R5");
    tick(1'b0, 1'b0, 1'b0, "R5 dominant");
    for (int i = 0; i < 11; i++) tick(1'b1, 1'b0, 1'b0, "R5");

    // R6 stuck dominant line
    tick(1'b1, 1'b1, 1'b0, "R8 re-enter");
    for (int i = 0; i < 30; i++) tick(1'b0, 1'b0, 1'b0, "R6");

    // R7 dominant noise only between ticks
    for (int i = 0; i < 11; i++) tick(1'b1, 1'b0, 1'b1, "R7");
    repeat (3) @(negedge clk);
    check(initAck, 1'b0, "R7 initAck after gap noise");

    // R10 loopback with dominant external line
    tick(1'b1, 1'b1, 1'b0, "R8 re-enter");
    loopEn = 1'b1;
    txBit = 1'b0;
    for (int i = 0; i < 11; i++) tick(1'b0, 1'b0, 1'b0, "R10");
    @(negedge clk);
    rxPin = 1'b1;
    #1 check(rxBit, 1'b0, "R10 rxBit follows txPin low");
    txBit = 1'b1;
    rxPin = 1'b0;
    #1 check(rxBit, 1'b1, "R10 rxBit follows txPin high");

    repeat (4) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule